// File: doc/BRIEF.md
# Front-Panel Frequency Digit Editor

This block holds the operator's choices for a function generator's front panel. It keeps a waveform slot number and a six-digit BCD frequency made of five integer digits and one tenths digit (format 00000.0 Hz). It also keeps a cursor that points at one of the frequency digits. Three debounced controls drive the edits: a line selector, an advance button and an increment button. They are sampled only on a slow periodic tick. An enable input freezes every edit while a remote host owns the instrument.

Each time the frequency changes, a serial converter turns the BCD digits into a binary phase increment in 0.1 Hz units. It handles one digit per clock, multiplying by ten and adding. The result is clamped to the legal range of 0.1 Hz to 20 kHz and announced with a one-cycle strobe. A slot-occupancy bitmap lets the increment button skip empty waveform slots on the slot line.

Top module: `freq_digit_editor`

## Requirements
- R1: After reset the slot is 0, the cursor is 0 and `freq_bcd` is 24'h010000 (1000.0 Hz). Digit k, counted from 0 at the ten-thousands digit to 5 at the tenths digit, sits in bits [23-4k:20-4k]. The first strobe after reset carries 10000.
- R2: A button acts only on a tick where it is high, `edit_en` is 1, and the same button was low at the previous tick. Holding a button across several ticks acts once.
- R3: When `line_sel`=1 (frequency line), an increment press adds one to the digit under the cursor. A 9 becomes 0, and no other digit changes.
- R4: When `line_sel`=1, an advance press moves the cursor from position k to k+1. From position 5 (tenths) it moves to 0 (ten-thousands).
- R5: When `line_sel`=0 (slot line), an advance press leaves the cursor and the digits unchanged.
- R6: When `line_sel`=0, an increment press moves the slot to the next higher slot whose `slot_used` bit is set, wrapping from the highest occupied slot to the lowest. The slot is unchanged if no bit is set, and it always stays below 14.
- R7: While `edit_en`=0, no press changes the digits, the cursor or the slot.
- R8: Every frequency change is followed, within seven clocks, by exactly one single-cycle `upd_stb`. While the strobe is high, `phase_inc` equals the digits read as a decimal number of tenths of a hertz.
- R9: A value of zero is reported as 1. A value above 200000 is reported as 200000, and 200000 itself passes unchanged.
- R10: A frequency change arriving while a conversion is running restarts it. Only the latest value is strobed.
- R11: A slot change produces no strobe.
- R12: When increment and advance are pressed on the same tick on the frequency line, the increment applies to the digit under the old cursor and the cursor then moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Periodic control sampling strobe |
| edit_en | input | 1 | 1 allows edits, 0 freezes them (host mode) |
| line_sel | input | 1 | 0 selects the slot line, 1 the frequency line |
| adv_btn | input | 1 | Debounced advance button level |
| inc_btn | input | 1 | Debounced increment button level |
| slot_used | input | 14 | Bit i set when waveform slot i holds a waveform |
| freq_bcd | output | 24 | Six BCD frequency digits, ten-thousands digit on top |
| cursor | output | 3 | Edited digit, 0 = ten-thousands, 5 = tenths |
| slot | output | 4 | Selected waveform slot |
| phase_inc | output | 20 | Clamped phase increment in 0.1 Hz units |
| upd_stb | output | 1 | One-cycle strobe marking a fresh phase_inc |

## Verification
A digit increment and a cursor advance can both land on the same tick. That makes the question which cursor position the increment uses. The bench presses both buttons together with the cursor on a known digit and expects the old position's digit to change and the cursor to move one place. A second collision puts a new digit change in the middle of a running conversion. That exchange passes if exactly one strobe arrives, it carries the later value, and no strobe for the earlier value appears.

// File: rtl/fde_pkg.sv
package fde_pkg;

    localparam int DIGITS_DEF    = 6;
    localparam int SLOTS_DEF     = 14;
    localparam int FMAX_DEF      = 200000;
    localparam int FMIN_DEF      = 1;
    localparam logic [23:0] RESET_BCD_DEF = 24'h010000;

    typedef logic [3:0] bcd_t;

    typedef enum logic {
        LINE_SLOT = 1'b0,
        LINE_FREQ = 1'b1
    } line_e;

    typedef struct packed {
        logic inc;
        logic adv;
    } press_t;

    function automatic bcd_t bcd_bump(input bcd_t d);
        return (d >= 4'd9) ? 4'd0 : d + 4'd1;
    endfunction

endpackage

// File: rtl/fde_sampler.sv
module fde_sampler
    import fde_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   en,
    input  logic   inc_lvl,
    input  logic   adv_lvl,
    output press_t act
);

    logic inc_q;
    logic adv_q;

    // previous levels are refreshed on every tick, also when frozen
    always_ff @(posedge clk) begin
        if (rst) begin
            inc_q <= 1'b0;
            adv_q <= 1'b0;
        end else if (tick) begin
            inc_q <= inc_lvl;
            adv_q <= adv_lvl;
        end
    end

    always_comb begin
        act.inc = tick & en & inc_lvl & ~inc_q;
        act.adv = tick & en & adv_lvl & ~adv_q;
    end

endmodule

// File: rtl/fde_digits.sv
module fde_digits
    import fde_pkg::*;
#(
    parameter int NUM_DIGITS = DIGITS_DEF,
    parameter logic [4*NUM_DIGITS-1:0] RESET_BCD = RESET_BCD_DEF,
    localparam int BCD_W = 4 * NUM_DIGITS,
    localparam int CUR_W = $clog2(NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  press_t           act,
    input  logic             line_sel,
    output logic [BCD_W-1:0] freq_bcd,
    output logic [CUR_W-1:0] cursor,
    output logic             freq_chg
);

    localparam logic [CUR_W-1:0] LAST_POS = CUR_W'(NUM_DIGITS - 1);

    logic on_freq;
    logic do_inc;
    logic do_adv;

    assign on_freq = (line_e'(line_sel) == LINE_FREQ);
    assign do_inc  = act.inc & on_freq;
    assign do_adv  = act.adv & on_freq;

    // digit under the pre-move cursor takes the increment
    always_ff @(posedge clk) begin
        if (rst) begin
            freq_bcd <= RESET_BCD;
        end else if (do_inc) begin
            for (int k = 0; k < NUM_DIGITS; k++) begin
                if (cursor == CUR_W'(k)) begin
                    freq_bcd[(BCD_W-4)-4*k +: 4] <= bcd_bump(freq_bcd[(BCD_W-4)-4*k +: 4]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cursor <= '0;
        end else if (do_adv) begin
            cursor <= (cursor == LAST_POS) ? '0 : cursor + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) freq_chg <= 1'b0;
        else     freq_chg <= do_inc;
    end

endmodule

// File: rtl/fde_slot.sv
module fde_slot
    import fde_pkg::*;
#(
    parameter int NUM_SLOTS = SLOTS_DEF,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  press_t               act,
    input  logic                 line_sel,
    input  logic [NUM_SLOTS-1:0] slot_used,
    output logic [SLOT_W-1:0]    slot
);

    // nearest occupied slot after cur, circularly; cur itself if none
    function automatic logic [SLOT_W-1:0] pick_next(
        input logic [NUM_SLOTS-1:0] used,
        input logic [SLOT_W-1:0]    cur
    );
        logic [SLOT_W-1:0] r;
        r = cur;
        for (int k = NUM_SLOTS - 1; k >= 1; k--) begin
            if (used[(int'(cur) + k) % NUM_SLOTS]) begin
                r = SLOT_W'((int'(cur) + k) % NUM_SLOTS);
            end
        end
        return r;
    endfunction

    logic step;
    assign step = act.inc & (line_e'(line_sel) == LINE_SLOT);

    always_ff @(posedge clk) begin
        if (rst)       slot <= '0;
        else if (step) slot <= pick_next(slot_used, slot);
    end

endmodule

// File: rtl/fde_bcd2bin.sv
module fde_bcd2bin
    import fde_pkg::*;
#(
    parameter int NUM_DIGITS = DIGITS_DEF,
    parameter int F_MIN = FMIN_DEF,
    parameter int F_MAX = FMAX_DEF,
    localparam int BCD_W = 4 * NUM_DIGITS,
    localparam int CUR_W = $clog2(NUM_DIGITS),
    localparam int INC_W = $clog2(10 ** NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BCD_W-1:0] bcd,
    output logic [INC_W-1:0] value,
    output logic             stb
);

    localparam logic [CUR_W-1:0] LAST_POS = CUR_W'(NUM_DIGITS - 1);

    logic             kick;
    logic             busy;
    logic [CUR_W-1:0] idx;
    logic [INC_W-1:0] acc;
    logic [INC_W-1:0] nxt;
    logic             go;

    function automatic logic [INC_W-1:0] clamp(input logic [INC_W-1:0] v);
        if (v < INC_W'(F_MIN))      return INC_W'(F_MIN);
        else if (v > INC_W'(F_MAX)) return INC_W'(F_MAX);
        else                        return v;
    endfunction

    assign go  = start | kick;
    assign nxt = INC_W'(acc * INC_W'(10)) + INC_W'(bcd[(BCD_W-4)-4*int'(idx) +: 4]);

    // one conversion is launched right after reset
    always_ff @(posedge clk) begin
        if (rst) kick <= 1'b1;
        else     kick <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            acc   <= '0;
            value <= '0;
            stb   <= 1'b0;
        end else if (go) begin
            busy <= 1'b1;
            idx  <= CUR_W'(1);
            acc  <= INC_W'(bcd[BCD_W-1 -: 4]);
            stb  <= 1'b0;
        end else if (busy) begin
            if (idx == LAST_POS) begin
                busy  <= 1'b0;
                value <= clamp(nxt);
                stb   <= 1'b1;
            end else begin
                acc <= nxt;
                idx <= idx + 1'b1;
                stb <= 1'b0;
            end
        end else begin
            stb <= 1'b0;
        end
    end

endmodule

// File: rtl/freq_digit_editor.sv
module freq_digit_editor
    import fde_pkg::*;
#(
    parameter int NUM_DIGITS = DIGITS_DEF,
    parameter int NUM_SLOTS  = SLOTS_DEF,
    parameter int F_MIN      = FMIN_DEF,
    parameter int F_MAX      = FMAX_DEF,
    parameter logic [4*NUM_DIGITS-1:0] RESET_BCD = RESET_BCD_DEF,
    localparam int BCD_W  = 4 * NUM_DIGITS,
    localparam int CUR_W  = $clog2(NUM_DIGITS),
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int INC_W  = $clog2(10 ** NUM_DIGITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 edit_en,
    input  logic                 line_sel,
    input  logic                 adv_btn,
    input  logic                 inc_btn,
    input  logic [NUM_SLOTS-1:0] slot_used,
    output logic [BCD_W-1:0]     freq_bcd,
    output logic [CUR_W-1:0]     cursor,
    output logic [SLOT_W-1:0]    slot,
    output logic [INC_W-1:0]     phase_inc,
    output logic                 upd_stb
);

    press_t act;
    logic   freq_chg;

    fde_sampler u_samp (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .en      (edit_en),
        .inc_lvl (inc_btn),
        .adv_lvl (adv_btn),
        .act     (act)
    );

    fde_digits #(
        .NUM_DIGITS (NUM_DIGITS),
        .RESET_BCD  (RESET_BCD)
    ) u_dig (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .line_sel (line_sel),
        .freq_bcd (freq_bcd),
        .cursor   (cursor),
        .freq_chg (freq_chg)
    );

    fde_slot #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .line_sel  (line_sel),
        .slot_used (slot_used),
        .slot      (slot)
    );

    fde_bcd2bin #(
        .NUM_DIGITS (NUM_DIGITS),
        .F_MIN      (F_MIN),
        .F_MAX      (F_MAX)
    ) u_conv (
        .clk   (clk),
        .rst   (rst),
        .start (freq_chg),
        .bcd   (freq_bcd),
        .value (phase_inc),
        .stb   (upd_stb)
    );

endmodule

// File: rtl/fde_check.sv
module fde_check #(
    parameter int NUM_DIGITS = 6,
    parameter int NUM_SLOTS  = 14,
    parameter int F_MIN      = 1,
    parameter int F_MAX      = 200000,
    localparam int BCD_W  = 4 * NUM_DIGITS,
    localparam int CUR_W  = $clog2(NUM_DIGITS),
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int INC_W  = $clog2(10 ** NUM_DIGITS)
) (
    input logic              clk,
    input logic              rst,
    input logic              edit_en,
    input logic              line_sel,
    input logic [BCD_W-1:0]  freq_bcd,
    input logic [CUR_W-1:0]  cursor,
    input logic [SLOT_W-1:0] slot,
    input logic [INC_W-1:0]  phase_inc,
    input logic              upd_stb
);

    // R4
    cursor_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cursor != $past(cursor)) |->
        (cursor == (($past(cursor) == CUR_W'(NUM_DIGITS - 1)) ? '0 : $past(cursor) + 1'b1)));

    // R5
    slot_line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(line_sel) |-> ($stable(cursor) && $stable(freq_bcd)));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(edit_en) |-> ($stable(cursor) && $stable(freq_bcd) && $stable(slot)));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

    // R9
    inc_range_chk: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> (phase_inc >= INC_W'(F_MIN) && phase_inc <= INC_W'(F_MAX)));

    // R6
    slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(slot) < NUM_SLOTS);

endmodule

bind freq_digit_editor fde_check #(
    .NUM_DIGITS (NUM_DIGITS),
    .NUM_SLOTS  (NUM_SLOTS),
    .F_MIN      (F_MIN),
    .F_MAX      (F_MAX)
) u_fde_check (
    .clk       (clk),
    .rst       (rst),
    .edit_en   (edit_en),
    .line_sel  (line_sel),
    .freq_bcd  (freq_bcd),
    .cursor    (cursor),
    .slot      (slot),
    .phase_inc (phase_inc),
    .upd_stb   (upd_stb)
);

// File: tb/freq_digit_editor_test.sv
module freq_digit_editor_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        edit_en = 1'b1;
    logic        line_sel = 1'b0;
    logic        adv_btn = 1'b0;
    logic        inc_btn = 1'b0;
    logic [13:0] slot_used = '0;
    logic [23:0] freq_bcd;
    logic [2:0]  cursor;
    logic [3:0]  slot;
    logic [19:0] phase_inc;
    logic        upd_stb;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];
    int md[6];
    int mcur = 0;
    int mslot = 0;

    always #(CLK_P/2) clk = ~clk;

    freq_digit_editor uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .edit_en   (edit_en),
        .line_sel  (line_sel),
        .adv_btn   (adv_btn),
        .inc_btn   (inc_btn),
        .slot_used (slot_used),
        .freq_bcd  (freq_bcd),
        .cursor    (cursor),
        .slot      (slot),
        .phase_inc (phase_inc),
        .upd_stb   (upd_stb)
    );

    function automatic int model_val();
        int v = 0;
        for (int i = 0; i < 6; i++) v = v * 10 + md[i];
        return v;
    endfunction

    function automatic int clampv(input int v);
        if (v < 1) return 1;
        if (v > 200000) return 200000;
        return v;
    endfunction

    function automatic logic [23:0] model_bcd();
        logic [23:0] b = '0;
        for (int i = 0; i < 6; i++) b[20-4*i +: 4] = 4'(md[i]);
        return b;
    endfunction

    function automatic int model_next_slot();
        for (int k = 1; k <= 14; k++) begin
            if (slot_used[(mslot + k) % 14]) return (mslot + k) % 14;
        end
        return mslot;
    endfunction

    task automatic check_state(input string tag);
        n_chk++;
        if (freq_bcd !== model_bcd()) begin
            n_err++;
            $display("FAIL %s freq_bcd actual %h expected %h", tag, freq_bcd, model_bcd());
        end
        n_chk++;
        if (int'(cursor) != mcur) begin
            n_err++;
            $display("FAIL %s cursor actual %0d expected %0d", tag, cursor, mcur);
        end
        n_chk++;
        if (int'(slot) != mslot) begin
            n_err++;
            $display("FAIL %s slot actual %0d expected %0d", tag, slot, mslot);
        end
    endtask

    // driver: updates the model, queues expected strobes, then drives a press tick and a release tick
    task automatic press_raw(input bit i, input bit a, input bit push_it);
        if (edit_en) begin
            if (line_sel) begin
                if (i) begin
                    md[mcur] = (md[mcur] + 1) % 10;
                    if (push_it) exp_q.push_back(clampv(model_val()));
                end
                if (a) mcur = (mcur + 1) % 6;
            end else if (i) begin
                mslot = model_next_slot();
            end
        end
        @(negedge clk);
        inc_btn = i; adv_btn = a; tick = 1'b1;
        @(negedge clk);
        inc_btn = 1'b0; adv_btn = 1'b0;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic press(input bit i, input bit a);
        press_raw(i, a, 1'b1);
        settle();
    endtask

    // monitor: every strobe must match the oldest expected value
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && upd_stb) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R8 unexpected strobe actual %0d expected none", phase_inc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (int'(phase_inc) != e) begin
                        n_err++;
                        $display("FAIL R8 phase_inc actual %0d expected %0d", phase_inc, e);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        md = '{0, 1, 0, 0, 0, 0};
        slot_used = 14'b10_0000_0000_1001;
        exp_q.push_back(10000); // R1 strobe after reset
        repeat (5) @(negedge clk);
        rst = 1'b0;
        settle();
        check_state("R1 reset");

        line_sel = 1'b1;
        press(1'b1, 1'b0);
        check_state("R3 increment");

        for (int k = 0; k < 5; k++) press(1'b0, 1'b1);
        check_state("R4 advance to tenths");
        press(1'b0, 1'b1);
        check_state("R4 wrap to ten-thousands");

        press(1'b1, 1'b1); // 21000.0 clamps; R9
        check_state("R12 simultaneous press");

        for (int k = 0; k < 9; k++) press(1'b1, 1'b0);
        check_state("R3 nine wraps to zero");

        for (int k = 0; k < 5; k++) press(1'b0, 1'b1);
        for (int k = 0; k < 8; k++) press(1'b1, 1'b0); // ends at zero -> 1 (R9)
        check_state("R9 zero frequency");

        for (int k = 0; k < 5; k++) press(1'b0, 1'b1);
        press(1'b1, 1'b0);
        check_state("R4 tenths digit");

        // R10 second change while the first conversion runs
        press_raw(1'b1, 1'b0, 1'b0);
        press_raw(1'b1, 1'b0, 1'b1);
        settle();
        check_state("R10 restart");

        // R2 button held across two ticks acts once
        md[mcur] = (md[mcur] + 1) % 10;
        exp_q.push_back(clampv(model_val()));
        @(negedge clk); inc_btn = 1'b1; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; inc_btn = 1'b0;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        settle();
        check_state("R2 held button");

        edit_en = 1'b0;
        press(1'b1, 1'b1);
        check_state("R7 frozen frequency line");
        line_sel = 1'b0;
        press(1'b1, 1'b0);
        check_state("R7 frozen slot line");
        edit_en = 1'b1;

        press(1'b0, 1'b1);
        check_state("R5 advance on slot line");

        press(1'b1, 1'b0);
        check_state("R6 slot to 3");
        press(1'b1, 1'b0);
        check_state("R6 slot to 13");
        press(1'b1, 1'b0);
        check_state("R6 wrap to 0 R11 no strobe");

        slot_used = '0;
        press(1'b1, 1'b0);
        check_state("R6 no occupied slot");

        slot_used = 14'b00_0000_0010_0000;
        press(1'b1, 1'b0);
        check_state("R6 only slot 5");
        press(1'b1, 1'b0);
        check_state("R6 single occupied stays");

        settle();
        n_chk++;
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL R8 missing strobes actual %0d pending expected 0", exp_q.size());
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule